// File: doc/BRIEF.md
# FEAC codeword validation receiver

This block receives the far-end alarm and control channel of a DS3 stream as a serial bit sequence, one bit per strobe. It locates 16-bit codewords in that sequence, keeps the six-bit codes of the ten most recent codewords in a sliding history, and decides by majority vote when a code becomes validated and when a validated code is withdrawn. Each of the two events sets its own status flag. Each flag can be masked onto a single interrupt line.

Software sees a small register view. It can read the validated code and a code-present flag. It can write two interrupt enables. A one-cycle read strobe clears both status flags. The decision logic is a two-state machine. `ST_SEARCH` means no code is held. `ST_HELD` means a validated code is held. The transition `SEARCH_TO_HELD` fires on a validation vote, and `HELD_TO_SEARCH` fires on a removal vote. A vote is taken only in the cycle after a new codeword has entered a full history.

Top module: `feac_rx`

## Requirements
- R1: A codeword is a window of 16 bits, taken in arrival order: a 0, six code bits, a 0, then eight 1s. The first code bit to arrive is code bit 5. After a codeword is taken, the search restarts with the next bit. A window whose tail is not eight 1s is not a codeword.
- R2: No vote is taken until ten codewords have been received since reset.
- R3: A code is validated when the newest codeword's code equals at least 8 of the 10 history entries. In the same cycle `code_present` goes to 1, `code_out` takes the code and `valid_sts` is set. This happens two clock edges after the edge that samples the codeword's last bit.
- R4: A held code is removed when at least 3 of the 10 history entries differ from it. `code_present` goes to 0 and `remove_sts` is set, with the same latency as R3.
- R5: While a code is held, no code can be validated. In each vote the removal test is applied to a held code before any validation test.
- R6: `sts_rd` clears both status flags on the next edge. A flag being set in that same cycle stays set.
- R7: The enables `valid_ie` and `remove_ie` reset to 0 and load from `cfg_valid_ie` and `cfg_remove_ie` when `cfg_wr` is 1. `irq` is (`valid_sts` AND `valid_ie`) OR (`remove_sts` AND `remove_ie`).
- R8: `code_out` keeps its value after a removal, and changes only when a code is validated.
- R9: After reset, all outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bit_valid | input | 1 | Strobe: `bit_in` carries a channel bit |
| bit_in | input | 1 | Serial channel bit |
| sts_rd | input | 1 | Status register read strobe |
| cfg_wr | input | 1 | Enable register write strobe |
| cfg_valid_ie | input | 1 | Write data for the valid interrupt enable |
| cfg_remove_ie | input | 1 | Write data for the remove interrupt enable |
| code_out | output | 6 | Most recently validated code |
| code_present | output | 1 | A validated code is currently held |
| valid_sts | output | 1 | Validation event status |
| remove_sts | output | 1 | Removal event status |
| valid_ie | output | 1 | Valid interrupt enable |
| remove_ie | output | 1 | Remove interrupt enable |
| irq | output | 1 | Masked interrupt |

## Verification
The assertions check several rules on every cycle. A rise of `code_present` must come with `valid_sts`, and a fall must come with `remove_sts`. `code_out` may change only at a validation. A read leaves a status flag set only when its event coincides with the read. With both enables clear, `irq` must stay low. The vote thresholds, the ten-codeword warm-up, the exact codeword framing and the rejection of a malformed word depend on the history contents. Only the bench scenarios can show these. The bench feeds all 64 codes and compares each outcome against its own model of the history.

// File: rtl/feac_pkg.sv
package feac_pkg;
    typedef enum logic [0:0] {
        ST_SEARCH = 1'b0,
        ST_HELD   = 1'b1
    } feac_state_e;
endpackage

// File: rtl/feac_cw_detect.sv
// Sliding window codeword finder: 0, code bits, 0, eight 1s.
module feac_cw_detect #(
    parameter int CODE_W = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bit_valid,
    input  logic              bit_in,
    output logic              cw_valid,
    output logic [CODE_W-1:0] cw_code
);
    localparam int FRAME_W = CODE_W + 10;
    localparam int CNT_W   = $clog2(FRAME_W + 1);

    logic [FRAME_W-1:0] win_q, win_nxt;
    logic [CNT_W-1:0]   cnt_q;
    logic               full, hit;

    always_comb begin
        win_nxt = {win_q[FRAME_W-2:0], bit_in};
        full    = (cnt_q >= CNT_W'(FRAME_W - 1));
        hit     = bit_valid && full && !win_nxt[FRAME_W-1] && !win_nxt[8] && (&win_nxt[7:0]);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            win_q    <= '0;
            cnt_q    <= '0;
            cw_valid <= 1'b0;
            cw_code  <= '0;
        end else begin
            cw_valid <= hit;
            if (bit_valid) begin
                win_q <= win_nxt;
                if (hit) begin
                    cnt_q   <= '0;
                    cw_code <= win_nxt[FRAME_W-2:9];
                end else if (cnt_q != CNT_W'(FRAME_W)) begin
                    cnt_q <= cnt_q + 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/feac_history.sv
// Shift history of recent codes plus vote counts.
module feac_history #(
    parameter int CODE_W = 6,
    parameter int DEPTH  = 10,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              push,
    input  logic [CODE_W-1:0] push_code,
    input  logic [CODE_W-1:0] held_code,
    output logic              eval,
    output logic              hist_full,
    output logic [CODE_W-1:0] newest,
    output logic [CNT_W-1:0]  same_cnt,
    output logic [CNT_W-1:0]  diff_cnt
);
    logic [CODE_W-1:0] hist_q [DEPTH];
    logic [CNT_W-1:0]  fill_q;
    logic [DEPTH-1:0]  same_vec, diff_vec;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hist_q[0] <= '0;
        end else if (push) begin
            hist_q[0] <= push_code;
        end
    end

    for (genvar i = 1; i < DEPTH; i++) begin : g_stage
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                hist_q[i] <= '0;
            end else if (push) begin
                hist_q[i] <= hist_q[i-1];
            end
        end
    end

    for (genvar i = 0; i < DEPTH; i++) begin : g_cmp
        assign same_vec[i] = (hist_q[i] == hist_q[0]);
        assign diff_vec[i] = (hist_q[i] != held_code);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fill_q <= '0;
            eval   <= 1'b0;
        end else begin
            eval <= push;
            if (push && fill_q != CNT_W'(DEPTH)) begin
                fill_q <= fill_q + 1'b1;
            end
        end
    end

    always_comb begin
        same_cnt = '0;
        diff_cnt = '0;
        for (int i = 0; i < DEPTH; i++) begin
            same_cnt = same_cnt + CNT_W'(same_vec[i]);
            diff_cnt = diff_cnt + CNT_W'(diff_vec[i]);
        end
    end

    assign hist_full = (fill_q == CNT_W'(DEPTH));
    assign newest    = hist_q[0];
endmodule

// File: rtl/feac_ctrl.sv
// Validation state machine, status flags, enables and interrupt.
module feac_ctrl
    import feac_pkg::*;
#(
    parameter int CODE_W     = 6,
    parameter int CNT_W      = 4,
    parameter int VALID_MIN  = 8,
    parameter int REMOVE_MIN = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              eval,
    input  logic              hist_full,
    input  logic [CODE_W-1:0] newest,
    input  logic [CNT_W-1:0]  same_cnt,
    input  logic [CNT_W-1:0]  diff_cnt,
    input  logic              sts_rd,
    input  logic              cfg_wr,
    input  logic              cfg_valid_ie,
    input  logic              cfg_remove_ie,
    output logic [CODE_W-1:0] code_out,
    output logic              code_present,
    output logic              valid_sts,
    output logic              remove_sts,
    output logic              valid_ie,
    output logic              remove_ie,
    output logic              irq
);
    feac_state_e state_q, state_d;
    logic        vote, ev_valid, ev_remove;

    assign vote = eval && hist_full;

    always_comb begin
        state_d   = state_q;
        ev_valid  = 1'b0;
        ev_remove = 1'b0;
        unique case (state_q)
            ST_SEARCH: begin
                if (vote && same_cnt >= CNT_W'(VALID_MIN)) begin
                    state_d  = ST_HELD;
                    ev_valid = 1'b1;
                end
            end
            ST_HELD: begin
                if (vote && diff_cnt >= CNT_W'(REMOVE_MIN)) begin
                    state_d   = ST_SEARCH;
                    ev_remove = 1'b1;
                end
            end
            default: state_d = ST_SEARCH;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_SEARCH;
        end else begin
            state_q <= state_d;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            code_out   <= '0;
            valid_sts  <= 1'b0;
            remove_sts <= 1'b0;
            valid_ie   <= 1'b0;
            remove_ie  <= 1'b0;
        end else begin
            if (ev_valid) begin
                code_out <= newest;
            end
            valid_sts  <= ev_valid  | (valid_sts  & ~sts_rd);
            remove_sts <= ev_remove | (remove_sts & ~sts_rd);
            if (cfg_wr) begin
                valid_ie  <= cfg_valid_ie;
                remove_ie <= cfg_remove_ie;
            end
        end
    end

    assign code_present = (state_q == ST_HELD);
    assign irq = (valid_sts & valid_ie) | (remove_sts & remove_ie);
endmodule

// File: rtl/feac_rx.sv
module feac_rx #(
    parameter int CODE_W     = 6,
    parameter int DEPTH      = 10,
    parameter int VALID_MIN  = 8,
    parameter int REMOVE_MIN = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bit_valid,
    input  logic              bit_in,
    input  logic              sts_rd,
    input  logic              cfg_wr,
    input  logic              cfg_valid_ie,
    input  logic              cfg_remove_ie,
    output logic [CODE_W-1:0] code_out,
    output logic              code_present,
    output logic              valid_sts,
    output logic              remove_sts,
    output logic              valid_ie,
    output logic              remove_ie,
    output logic              irq
);
    localparam int CNT_W = $clog2(DEPTH + 1);

    logic              cw_valid;
    logic [CODE_W-1:0] cw_code;
    logic              eval, hist_full;
    logic [CODE_W-1:0] newest;
    logic [CNT_W-1:0]  same_cnt, diff_cnt;

    feac_cw_detect #(.CODE_W(CODE_W)) det_i (
        .clk(clk), .rst_n(rst_n), .bit_valid(bit_valid), .bit_in(bit_in),
        .cw_valid(cw_valid), .cw_code(cw_code)
    );

    feac_history #(.CODE_W(CODE_W), .DEPTH(DEPTH)) hist_i (
        .clk(clk), .rst_n(rst_n), .push(cw_valid), .push_code(cw_code),
        .held_code(code_out), .eval(eval), .hist_full(hist_full),
        .newest(newest), .same_cnt(same_cnt), .diff_cnt(diff_cnt)
    );

    feac_ctrl #(.CODE_W(CODE_W), .CNT_W(CNT_W), .VALID_MIN(VALID_MIN),
                .REMOVE_MIN(REMOVE_MIN)) ctrl_i (
        .clk(clk), .rst_n(rst_n), .eval(eval), .hist_full(hist_full),
        .newest(newest), .same_cnt(same_cnt), .diff_cnt(diff_cnt),
        .sts_rd(sts_rd), .cfg_wr(cfg_wr), .cfg_valid_ie(cfg_valid_ie),
        .cfg_remove_ie(cfg_remove_ie), .code_out(code_out),
        .code_present(code_present), .valid_sts(valid_sts),
        .remove_sts(remove_sts), .valid_ie(valid_ie), .remove_ie(remove_ie),
        .irq(irq)
    );
endmodule

// File: rtl/feac_rx_chk.sv
module feac_rx_chk #(
    parameter int CODE_W = 6
) (
    input logic              clk,
    input logic              rst_n,
    input logic              sts_rd,
    input logic              cfg_wr,
    input logic [CODE_W-1:0] code_out,
    input logic              code_present,
    input logic              valid_sts,
    input logic              remove_sts,
    input logic              valid_ie,
    input logic              remove_ie,
    input logic              irq
);
    p_valid_on_rise_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(code_present) |-> valid_sts);

    p_remove_on_fall_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(code_present) |-> remove_sts);

    p_code_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !$rose(code_present) |-> $stable(code_out));

    p_rd_clear_valid_r6: assert property (@(posedge clk) disable iff (!rst_n)
        sts_rd |=> (valid_sts == $rose(code_present)));

    p_rd_clear_remove_r6: assert property (@(posedge clk) disable iff (!rst_n)
        sts_rd |=> (remove_sts == $fell(code_present)));

    p_irq_masked_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!valid_ie && !remove_ie) |-> !irq);

    p_ie_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_wr |=> ($stable(valid_ie) && $stable(remove_ie)));
endmodule

bind feac_rx feac_rx_chk #(.CODE_W(CODE_W)) chk_i (
    .clk(clk), .rst_n(rst_n), .sts_rd(sts_rd), .cfg_wr(cfg_wr),
    .code_out(code_out), .code_present(code_present), .valid_sts(valid_sts),
    .remove_sts(remove_sts), .valid_ie(valid_ie), .remove_ie(remove_ie),
    .irq(irq)
);

// File: tb/feac_rx_tb_top.sv
`timescale 1ns/1ps
module feac_rx_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bit_valid = 1'b0, bit_in = 1'b1, sts_rd = 1'b0;
    logic       cfg_wr = 1'b0, cfg_valid_ie = 1'b0, cfg_remove_ie = 1'b0;
    logic [5:0] code_out;
    logic       code_present, valid_sts, remove_sts, valid_ie, remove_ie, irq;

    int checks = 0;
    int errors = 0;

    int hist [10];
    int fill = 0;
    bit m_present = 0, m_v = 0, m_r = 0, m_vie = 0, m_rie = 0;
    int m_held = 0;

    always #5 clk = ~clk;

    feac_rx dut_i (
        .clk(clk), .rst_n(rst_n), .bit_valid(bit_valid), .bit_in(bit_in),
        .sts_rd(sts_rd), .cfg_wr(cfg_wr), .cfg_valid_ie(cfg_valid_ie),
        .cfg_remove_ie(cfg_remove_ie), .code_out(code_out),
        .code_present(code_present), .valid_sts(valid_sts),
        .remove_sts(remove_sts), .valid_ie(valid_ie), .remove_ie(remove_ie),
        .irq(irq)
    );

    task automatic chk(string req, string what, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic check_all(string req);
        chk(req, "code_present", int'(code_present), int'(m_present));
        chk(req, "code_out", int'(code_out), m_held);
        chk(req, "valid_sts", int'(valid_sts), int'(m_v));
        chk(req, "remove_sts", int'(remove_sts), int'(m_r));
        chk(req, "irq", int'(irq), int'((m_v & m_vie) | (m_r & m_rie)));
    endtask

    // Model of the vote rules, from the requirements.
    task automatic model_push(int c, bit rd);
        bit ev_v = 0, ev_r = 0;
        for (int i = 9; i > 0; i--) hist[i] = hist[i-1];
        hist[0] = c;
        if (fill < 10) fill++;
        if (fill == 10) begin
            if (m_present) begin
                int d = 0;
                for (int i = 0; i < 10; i++) if (hist[i] != m_held) d++;
                if (d >= 3) begin m_present = 0; ev_r = 1; end
            end else begin
                int s = 0;
                for (int i = 0; i < 10; i++) if (hist[i] == hist[0]) s++;
                if (s >= 8) begin m_present = 1; m_held = c; ev_v = 1; end
            end
        end
        if (rd) begin m_v = ev_v; m_r = ev_r; end
        else begin m_v = m_v | ev_v; m_r = m_r | ev_r; end
    endtask

    task automatic send_bits(logic [15:0] w);
        for (int i = 15; i >= 0; i--) begin
            @(negedge clk);
            bit_valid = 1'b1;
            bit_in = w[i];
        end
        @(negedge clk);
        bit_valid = 1'b0;
        bit_in = 1'b1;
    endtask

    // Sends one codeword; rd raises sts_rd in the cycle the vote result lands.
    task automatic send_cw(int c, bit rd, string req);
        send_bits({1'b0, 6'(c), 1'b0, 8'hFF});
        @(negedge clk);
        sts_rd = rd;
        @(negedge clk);
        sts_rd = 1'b0;
        model_push(c, rd);
        check_all(req);
    endtask

    task automatic do_read(string req);
        @(negedge clk);
        sts_rd = 1'b1;
        @(negedge clk);
        sts_rd = 1'b0;
        m_v = 0;
        m_r = 0;
        check_all(req);
    endtask

    task automatic write_ie(bit v, bit r, string req);
        @(negedge clk);
        cfg_wr = 1'b1;
        cfg_valid_ie = v;
        cfg_remove_ie = r;
        @(negedge clk);
        cfg_wr = 1'b0;
        m_vie = v;
        m_rie = r;
        chk(req, "valid_ie", int'(valid_ie), int'(v));
        chk(req, "remove_ie", int'(remove_ie), int'(r));
        check_all(req);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual=timeout expected=done");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        for (int i = 0; i < 10; i++) hist[i] = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R9 reset state
        check_all("R9");
        chk("R9", "valid_ie", int'(valid_ie), 0);
        chk("R9", "remove_ie", int'(remove_ie), 0);

        // R2: nine identical codewords give no vote
        for (int k = 0; k < 9; k++) send_cw(6'h15, 1'b0, "R2");
        // R3: the tenth validates
        send_cw(6'h15, 1'b0, "R3");
        chk("R3", "validated", int'(code_present), 1);
        do_read("R6");

        // R5: two differing codes keep the held code
        send_cw(6'h2A, 1'b0, "R5");
        send_cw(6'h2A, 1'b0, "R5");
        // R1: malformed word (seven 1s then 0) must not enter the history
        send_bits({1'b0, 6'h2A, 1'b0, 8'hFE});
        repeat (3) @(negedge clk);
        check_all("R1");
        chk("R1", "bad word ignored", int'(code_present), 1);
        // R4: third differing code removes; R8 code retained
        send_cw(6'h2A, 1'b0, "R4");
        chk("R4", "removed", int'(code_present), 0);
        chk("R8", "code kept", int'(code_out), 6'h15);

        // R7 enables and irq masking
        write_ie(1'b1, 1'b1, "R7");
        chk("R7", "irq on remove", int'(irq), 1);
        write_ie(1'b0, 1'b0, "R7");
        chk("R7", "irq masked", int'(irq), 0);
        write_ie(1'b1, 1'b1, "R7");

        // R6: reads coinciding with votes; set wins on the validating one
        for (int k = 0; k < 5; k++) send_cw(6'h2A, 1'b1, "R6");
        chk("R6", "set wins", int'(valid_sts), 1);
        chk("R3", "new code", int'(code_out), 6'h2A);

        // R1/R3/R4 sweep over all codes
        for (int c = 0; c < 64; c++) begin
            for (int k = 0; k < 10; k++) send_cw(c, (k == 9), "R1");
        end
        write_ie(1'b0, 1'b1, "R7");

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule